// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block finds out what kind of monitor is attached by exercising three
open-drain sense lines, called A, B and C. After a start pulse it first charges
all three lines high for a short time and then lets them float. It then pulls
each line low in turn. Each step lasts for a settling window, and at the end of
that window the block reads the levels of the lines it is not driving. The
readings from the four sampling steps are packed into an 11-bit code. Logic
further along uses this code to choose a display mode.

Each line has its own drive-enable and drive-value output, which go to an
open-drain pad. The line levels come back on a three-bit input. This input can
pass through a configurable synchroniser before it is sampled. Settling windows
are counted in delay units, and each unit is a parameterised number of clock
cycles. `busy` stays high while a run is in progress. `done` is pulsed for one
cycle when the new code appears.

Top module: `mon_sense_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `drive_en` and `sense_code` are all zero and `drive_val` is 3'b111. Line index 0 is A, 1 is B and 2 is C in every three-bit vector.
- R2: A `start` pulse while idle raises `busy` on the next cycle. It also opens a charge phase of SHORT_UNITS*UNIT_CYCLES cycles with `drive_en`=3'b111 and `drive_val`=3'b111. A complete run keeps `busy` high for SHORT_UNITS*UNIT_CYCLES + 4*LONG_UNITS*UNIT_CYCLES cycles.
- R3: The charge phase is followed by a float phase of LONG_UNITS*UNIT_CYCLES cycles with `drive_en`=3'b000. At its end the lines are sampled into code bit 10 (C), bit 9 (B) and bit 8 (A).
- R4: The next phase drives A low (`drive_en`=3'b001, `drive_val`=3'b110) for LONG_UNITS*UNIT_CYCLES cycles. At its end C is sampled into code bit 5 and B into bit 4.
- R5: The next phase drives B low (`drive_en`=3'b010, `drive_val`=3'b101) for the same length. At its end C is sampled into code bit 3 and A into bit 2.
- R6: The last phase drives C low (`drive_en`=3'b100, `drive_val`=3'b011) for the same length. At its end B is sampled into code bit 1 and A into bit 0. A line is never given a low value unless its enable is set.
- R7: Code bits 7:6 are always zero.
- R8: After the last sample all drivers are released, `busy` falls and `done` is high for exactly one cycle. In that cycle `sense_code` shows the new code, and the code then holds unchanged until the next `done`.
- R9: A `start` pulse while `busy` is high is ignored. The run keeps its phase sequence and its length.
- R10: A `start` pulse in the same cycle as `done` is accepted, and `busy` rises again on the next cycle.
- R11: Each sample is the line level SYNC_STAGES cycles before the last cycle of the phase it belongs to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a sense run |
| line_in | input | 3 | Levels of the sense lines {C,B,A} |
| drive_en | output | 3 | Per-line driver enable {C,B,A} |
| drive_val | output | 3 | Per-line driven level {C,B,A} |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when a new code is presented |
| sense_code | output | 11 | Packed sense code |

## Verification
The completion of one run and the launch of the next can fall in the same cycle.
The bench provokes this by raising `start` in the very cycle that shows `done`.
It then checks that `busy` and the charge drive pattern appear on the next
cycle, and that the finished code stays intact while the new run samples its own
values. A reference model driven by the same inputs is compared with the design
on every clock. Start pulses in the middle of a run, static monitor ties, bridged
lines and pseudo-random line levels give each sampling window several distinct
patterns to check.

// File: rtl/mss_pkg.sv
package mss_pkg;
   localparam int LINES  = 3;
   localparam int CODE_W = 11;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_PRECHG  = 3'd1,
      PH_RELEASE = 3'd2,
      PH_A_LOW   = 3'd3,
      PH_B_LOW   = 3'd4,
      PH_C_LOW   = 3'd5
   } phase_e;

   typedef struct packed {
      logic [LINES-1:0] en;
      logic [LINES-1:0] val;
   } drive_t;

   // Pad drive pattern per phase; index 0 = A, 1 = B, 2 = C
   function automatic drive_t drive_of(phase_e ph);
      drive_t d;
      case (ph)
         PH_PRECHG: d = '{en: 3'b111, val: 3'b111};
         PH_A_LOW:  d = '{en: 3'b001, val: 3'b110};
         PH_B_LOW:  d = '{en: 3'b010, val: 3'b101};
         PH_C_LOW:  d = '{en: 3'b100, val: 3'b011};
         default:   d = '{en: 3'b000, val: 3'b111};
      endcase
      return d;
   endfunction

   function automatic phase_e next_phase(phase_e ph);
      phase_e n;
      case (ph)
         PH_PRECHG:  n = PH_RELEASE;
         PH_RELEASE: n = PH_A_LOW;
         PH_A_LOW:   n = PH_B_LOW;
         PH_B_LOW:   n = PH_C_LOW;
         default:    n = PH_IDLE;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/mss_line_sync.sv
module mss_line_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mss_settle_timer.sv
module mss_settle_timer #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/mss_phase_ctrl.sv
module mss_phase_ctrl
   import mss_pkg::*;
#(
   parameter int CNT_W    = 11,
   parameter int PRE_LEN  = 200,
   parameter int STEP_LEN = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             expired,
   output phase_e           phase,
   output logic             launch,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             strobe,
   output logic             last,
   output logic             done
);
   logic active;

   assign active   = (phase != PH_IDLE);
   assign launch   = !active && start;
   assign strobe   = active && (phase != PH_PRECHG) && expired;
   assign last     = strobe && (phase == PH_C_LOW);
   assign load     = launch || (active && expired && (phase != PH_C_LOW));
   assign load_val = active ? CNT_W'(STEP_LEN - 1) : CNT_W'(PRE_LEN - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         done  <= 1'b0;
      end else begin
         done <= last;
         if (launch)                phase <= PH_PRECHG;
         else if (active && expired) phase <= next_phase(phase);
      end
   end
endmodule

// File: rtl/mss_code_pack.sv
module mss_code_pack
   import mss_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              strobe,
   input  logic              last,
   input  phase_e            phase,
   input  logic [LINES-1:0]  lines,
   output logic [CODE_W-1:0] code
);
   logic [CODE_W-1:0] shadow, merged;

   // Place the lines not driven in this phase into their code fields
   always_comb begin
      merged = shadow;
      case (phase)
         PH_RELEASE: merged[10:8] = lines;                 // C,B,A
         PH_A_LOW:   merged[5:4]  = {lines[2], lines[1]};  // C,B
         PH_B_LOW:   begin
                        merged[3] = lines[2];              // C
                        merged[2] = lines[0];              // A
                     end
         PH_C_LOW:   merged[1:0]  = {lines[1], lines[0]};  // B,A
         default:    merged = shadow;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         code   <= '0;
      end else begin
         if (launch)      shadow <= '0;
         else if (strobe) shadow <= merged;
         if (last)        code   <= merged;
      end
   end
endmodule

// File: rtl/mon_sense_seq.sv
module mon_sense_seq
   import mss_pkg::*;
#(
   parameter int UNIT_CYCLES = 1,
   parameter int SHORT_UNITS = 200,
   parameter int LONG_UNITS  = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        line_in,
   output logic [2:0]        drive_en,
   output logic [2:0]        drive_val,
   output logic              busy,
   output logic              done,
   output logic [10:0]       sense_code
);
   localparam int PRE_LEN  = SHORT_UNITS * UNIT_CYCLES;
   localparam int STEP_LEN = LONG_UNITS * UNIT_CYCLES;
   localparam int MAX_LEN  = (PRE_LEN > STEP_LEN) ? PRE_LEN : STEP_LEN;
   localparam int CNT_W    = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

   generate
      if (UNIT_CYCLES < 1 || SHORT_UNITS < 1 || LONG_UNITS < 1) begin : g_bad_len
         $error("mon_sense_seq: phase lengths must be at least one cycle");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mon_sense_seq: SYNC_STAGES must lie in 0..4");
      end
      if (STEP_LEN <= SYNC_STAGES) begin : g_bad_window
         $error("mon_sense_seq: settling window shorter than synchroniser");
      end
   endgenerate

   phase_e           phase;
   logic             launch, load, strobe, last, expired;
   logic [CNT_W-1:0] load_val;
   logic [LINES-1:0] lines_s;
   drive_t           drv;

   mss_line_sync #(.STAGES(SYNC_STAGES), .W(LINES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(lines_s));

   mss_settle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .expired(expired));

   mss_phase_ctrl #(.CNT_W(CNT_W), .PRE_LEN(PRE_LEN), .STEP_LEN(STEP_LEN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .expired(expired),
      .phase(phase), .launch(launch), .load(load), .load_val(load_val),
      .strobe(strobe), .last(last), .done(done));

   mss_code_pack u_pack (
      .clk(clk), .rst_n(rst_n), .launch(launch), .strobe(strobe),
      .last(last), .phase(phase), .lines(lines_s), .code(sense_code));

   assign drv       = drive_of(phase);
   assign drive_en  = drv.en;
   assign drive_val = drv.val;
   assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/mss_checker.sv
module mss_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic [2:0]  drive_en,
   input logic [2:0]  drive_val,
   input logic        busy,
   input logic        done,
   input logic [10:0] sense_code
);
   // R8: done lasts one cycle only
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: done only appears once the run is over
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8: the code changes only together with done
   assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(sense_code));

   // R8: no driver stays on outside a run
   assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (drive_en == 3'b000));

   // R2: every run opens with all three lines charged high
   assert_charge_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (drive_en == 3'b111 && drive_val == 3'b111));

   // R10: a start in the done cycle launches a new run
   assert_b2b_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> busy);

   // R4: outside the charge phase at most one line is driven
   assert_single_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en != 3'b111) |-> $onehot0(drive_en));

   always @(posedge clk) begin
      if (rst_n) begin
         // R6: a low level is only ever presented on an enabled driver
         assert_low_enabled_R6: assert ((~drive_val & ~drive_en) == 3'b000);
         // R7: unused code field stays zero
         assert_bits76_R7: assert (sense_code[7:6] == 2'b00);
      end
   end
endmodule

bind mon_sense_seq mss_checker i_mss_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .drive_en(drive_en),
   .drive_val(drive_val), .busy(busy), .done(done), .sense_code(sense_code));

// File: tb/test_mon_sense_seq.sv
module test_mon_sense_seq;
   localparam int UNIT  = 2;
   localparam int SHORT = 3;
   localparam int LONG  = 7;
   localparam int SYNC  = 2;
   localparam int PRE   = SHORT * UNIT;
   localparam int STEP  = LONG * UNIT;
   localparam int RUN   = PRE + 4 * STEP;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  line_in;
   logic [2:0]  drive_en, drive_val;
   logic        busy, done;
   logic [10:0] sense_code;

   logic [2:0]  pull = 3'b111;
   logic        bridge = 1'b0;
   logic        rnd = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   logic [2:0]  line_neg = 3'b000;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   mon_sense_seq #(.UNIT_CYCLES(UNIT), .SHORT_UNITS(SHORT), .LONG_UNITS(LONG),
                   .SYNC_STAGES(SYNC)) i_mon_sense_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .line_in(line_in),
      .drive_en(drive_en), .drive_val(drive_val), .busy(busy), .done(done),
      .sense_code(sense_code));

   // Open-drain line model: driven lines show their value, others their tie;
   // an A-B bridge makes both read the wired-AND of the two.
   function automatic logic [2:0] levels(logic [2:0] en, logic [2:0] val,
                                         logic [2:0] p, logic br);
      logic [2:0] l;
      for (int i = 0; i < 3; i++) l[i] = en[i] ? val[i] : p[i];
      if (br) begin
         l[0] = l[0] & l[1];
         l[1] = l[0];
      end
      return l;
   endfunction

   function automatic logic [5:0] exp_drive(int ph);
      case (ph)
         1: return {3'b111, 3'b111};
         3: return {3'b001, 3'b110};
         4: return {3'b010, 3'b101};
         5: return {3'b100, 3'b011};
         default: return {3'b000, 3'b111};
      endcase
   endfunction

   function automatic logic [10:0] exp_code(logic [2:0] p, logic br);
      logic [10:0] c = '0;
      logic [2:0]  l;
      l = levels(3'b000, 3'b111, p, br);
      c[10] = l[2]; c[9] = l[1]; c[8] = l[0];
      l = levels(3'b001, 3'b110, p, br);
      c[5] = l[2]; c[4] = l[1];
      l = levels(3'b010, 3'b101, p, br);
      c[3] = l[2]; c[2] = l[0];
      l = levels(3'b100, 3'b011, p, br);
      c[1] = l[1]; c[0] = l[0];
      return c;
   endfunction

   always_comb line_in = rnd ? lfsr[2:0] : levels(drive_en, drive_val, pull, bridge);

   always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference model, updated each rising edge from inputs seen at the falling edge
   int          m_ph = 0, m_cnt = 0;
   logic        m_done = 1'b0;
   logic [10:0] m_code = '0, m_sh = '0;
   logic [2:0]  hist [$] = '{3'b0, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0, 3'b0};

   always @(posedge clk) begin
      logic [2:0] s;
      hist.push_front(line_neg);
      void'(hist.pop_back());
      s = hist[SYNC];   // R11: level SYNC cycles before the sampling edge
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_code = '0; m_sh = '0; m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (m_ph == 0) begin
            if (start) begin m_ph = 1; m_cnt = PRE; m_sh = '0; end
         end else if (m_cnt > 1) begin
            m_cnt--;
         end else begin
            case (m_ph)
               2: begin m_sh[10] = s[2]; m_sh[9] = s[1]; m_sh[8] = s[0]; end
               3: begin m_sh[5] = s[2]; m_sh[4] = s[1]; end
               4: begin m_sh[3] = s[2]; m_sh[2] = s[0]; end
               5: begin m_sh[1] = s[1]; m_sh[0] = s[0]; end
               default: ;
            endcase
            if (m_ph == 5) begin m_ph = 0; m_code = m_sh; m_done = 1'b1; end
            else begin m_ph++; m_cnt = STEP; end
         end
      end
   end

   always @(negedge clk) begin
      string dtag;
      line_neg <= line_in;
      case (m_ph)
         0: dtag = "R8 drive idle";
         1: dtag = "R2 drive charge";
         2: dtag = "R3 drive float";
         3: dtag = "R4 drive A low";
         4: dtag = "R5 drive B low";
         default: dtag = "R6 drive C low";
      endcase
      chk(dtag, {drive_en, drive_val}, exp_drive(m_ph));
      chk("R2 R9 busy", busy, (m_ph != 0));
      chk("R8 done", done, m_done);
      chk("R3 R4 R5 R6 R11 code", sense_code, m_code);
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL R8 watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_one(logic [2:0] p, logic br, logic r, logic mid_start,
                          logic b2b);
      int n = 0;
      logic [10:0] held;
      pull = p; bridge = br; rnd = r;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) begin
         if (busy) n++;
         start = mid_start && (n == 10 || n == PRE + STEP);
         @(negedge clk);
      end
      start = 1'b0;
      chk(mid_start ? "R9 run length" : "R2 run length", n, RUN);
      chk("R8 released at done", {busy, drive_en}, 4'b0000);
      if (!r) chk("R3 R4 R5 R6 packed code", sense_code, exp_code(p, br));
      chk("R7 bits 7:6", sense_code[7:6], 2'b00);
      held = sense_code;
      if (b2b) begin
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk("R10 restart busy", busy, 1'b1);
         chk("R10 restart drive", {drive_en, drive_val}, 6'b111111);
         chk("R8 code held in new run", sense_code, held);
         while (!done) @(negedge clk);
         chk("R10 second code", sense_code, exp_code(p, br));
      end else begin
         repeat (3) @(negedge clk);
         chk("R8 done single", done, 1'b0);
         chk("R8 code held", sense_code, held);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {busy, done, drive_en, drive_val, sense_code},
          {2'b00, 3'b000, 3'b111, 11'h000});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 after reset", {busy, done, drive_en, drive_val, sense_code},
          {2'b00, 3'b000, 3'b111, 11'h000});

      run_one(3'b111, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R3 all-high code", sense_code, 11'h73F);
      run_one(3'b010, 1'b0, 1'b0, 1'b0, 1'b0);
      run_one(3'b101, 1'b1, 1'b0, 1'b0, 1'b0);
      run_one(3'b000, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R9 grounded code", sense_code, 11'h000);
      run_one(3'b110, 1'b1, 1'b0, 1'b0, 1'b1);
      run_one(3'b011, 1'b0, 1'b0, 1'b1, 1'b1);
      for (int k = 0; k < 6; k++) run_one(3'b111, 1'b0, 1'b1, k[0], 1'b0);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule